// File: doc/BRIEF.md
# DMA Command Queue with Tag-Group Ordering

This block collects a DMA command through a small set of memory-mapped registers: local address, effective address (high and low words), byte count with tag, and class with opcode. It starts the enqueue when software reads the status register. That read checks the transfer size and the address alignment. A command that passes and finds room is placed in a queue of fixed depth. The same read returns a status code that tells software whether the command was accepted, rejected because the queue is full, or rejected as malformed.

Queued commands go to a transfer engine over a valid/ready handshake. Each issued command carries a short identifier. The engine returns that identifier with a done pulse when the transfer finishes. The block then frees the entry and reports the tag of the finished command on a completion output.

Each command belongs to one of 32 tag groups. Plain commands carry no ordering constraint and issue oldest-first whenever the engine is ready. A fenced command waits until every older command in its tag group has finished. A barrier command waits for the older commands of its group, and every younger command of the group waits for the barrier. A command that is held back never blocks commands of other groups.

Top module: `dmaq_top`

## Requirements
- R1: A read of register 5 (status) with a legal command and room in the queue enqueues the command and returns 0 in data bits 1:0 on the cycle after the read. The command later appears at the engine port.
- R2: Legal byte counts are 1, 2, 4 or 8, or a nonzero multiple of 16 no larger than 16384. Any other count returns status 2 and is not enqueued.
- R3: For counts below 16, both the local address and the effective address must be multiples of the count. For larger counts, both must be multiples of 16. A violation returns status 2 and is not enqueued.
- R4: The queue holds 16 commands. An attempt while it is full returns status 1 and leaves the queue unchanged.
- R5: A command that is malformed returns status 2 even when the queue is full.
- R6: Register 3 carries the byte count in bits 31:16 and the tag in bits 4:0. Register 4 carries the class in bits 31:16, the ordering field in bits 1:0 (0 plain, 1 fence, 2 or 3 barrier) and the direction in bit 2. These fields reach the engine port unchanged. Registers 0, 1 and 2 hold the local address, the upper effective-address word and the lower effective-address word.
- R7: Plain commands issue in the order they were enqueued while the engine is ready.
- R8: A fenced command does not issue before every older command of its tag group has completed.
- R9: A barrier command does not issue before the older commands of its group complete. Younger commands of its group do not issue before the barrier completes.
- R10: A command that is held by a fence or a barrier does not delay commands of other tag groups.
- R11: A done pulse for an issued identifier produces a completion pulse carrying that command's tag one cycle later.
- R12: After reset the engine request, the completion output and the read data are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of the status register attempts the enqueue |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the read |
| eng_valid | output | 1 | A command is offered to the engine |
| eng_ready | input | 1 | Engine accepts the offered command |
| eng_id | output | 5 | Identifier of the offered command |
| eng_tag | output | 5 | Tag group of the offered command |
| eng_dir | output | 1 | Direction bit of the offered command |
| eng_cls | output | 16 | Class of the offered command |
| eng_size | output | 16 | Byte count of the offered command |
| eng_lsa | output | 32 | Local address of the offered command |
| eng_ea | output | 64 | Effective address of the offered command |
| eng_done | input | 1 | Engine reports a finished command |
| eng_done_id | input | 5 | Identifier of the finished command |
| cpl_valid | output | 1 | Completion pulse |
| cpl_tag | output | 5 | Tag of the completed command |

## Verification
Ordering is the hardest behaviour to reach from the ports. Several commands of one tag group must be resident together, and an unrelated group must sit behind them. The issue time of a held command must then be compared with the done time of its predecessor. To set this up, the bench holds the engine's ready low while it loads each scenario, then releases it with a long completion delay, so a fence or barrier is visibly parked while another group's command passes it. The bench logs the cycles of every issue and every done and compares them.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;

    localparam int TAG_W = 5;
    localparam int SZ_W  = 16;

    // register indices
    localparam logic [2:0] RA_LSA    = 3'd0;
    localparam logic [2:0] RA_EAH    = 3'd1;
    localparam logic [2:0] RA_EAL    = 3'd2;
    localparam logic [2:0] RA_SZTAG  = 3'd3;
    localparam logic [2:0] RA_CLSCMD = 3'd4;
    localparam logic [2:0] RA_STAT   = 3'd5;

    // enqueue result codes
    localparam logic [1:0] ST_OK   = 2'd0;
    localparam logic [1:0] ST_FULL = 2'd1;
    localparam logic [1:0] ST_BAD  = 2'd2;

    typedef enum logic [1:0] {
        ORD_FREE  = 2'd0,
        ORD_FENCE = 2'd1,
        ORD_BAR   = 2'd2,
        ORD_BAR2  = 2'd3
    } ord_e;

endpackage

// File: rtl/dmaq_check.sv
// Size and natural-alignment screen for one command descriptor.
module dmaq_check #(
    parameter int MAX_BYTES = 16384,
    parameter int SIZE_W    = 16
) (
    input  logic [SIZE_W-1:0] size,
    input  logic [3:0]        lsa_lo,
    input  logic [3:0]        ea_lo,
    output logic              ok
);
    logic       small_sz;
    logic       multi_sz;
    logic [3:0] mask;
    logic       aligned;

    always_comb begin
        small_sz = (size == SIZE_W'(1)) || (size == SIZE_W'(2)) ||
                   (size == SIZE_W'(4)) || (size == SIZE_W'(8));
        multi_sz = (size != '0) && (size[3:0] == 4'd0) &&
                   (size <= SIZE_W'(MAX_BYTES));
        mask     = small_sz ? (size[3:0] - 4'd1) : 4'hF;
        aligned  = (((lsa_lo | ea_lo) & mask) == 4'd0);
        ok       = (small_sz || multi_sz) && aligned;
    end
endmodule

// File: rtl/dmaq_pick.sv
// Chooses the oldest entry whose tag-group ordering allows issue.
module dmaq_pick
    import dmaq_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]       vld,
    input  logic [DEPTH-1:0]       iss,
    input  logic [DEPTH*TAG_W-1:0] tags,
    input  logic [2*DEPTH-1:0]     ords,
    output logic                   any,
    output logic [IDX_W-1:0]       idx
);
    logic [DEPTH-1:0] go_vec;

    for (genvar g = 0; g < DEPTH; g++) begin : g_elig
        logic blk;
        always_comb begin
            blk = 1'b0;
            for (int j = 0; j < g; j++) begin
                // an older live entry of the same group holds a fence/barrier
                // back, and an older barrier holds everything back
                if (vld[j] && (tags[j*TAG_W +: TAG_W] == tags[g*TAG_W +: TAG_W]) &&
                    ((ords[2*g +: 2] != 2'b00) || ords[2*j+1])) begin
                    blk = 1'b1;
                end
            end
        end
        assign go_vec[g] = vld[g] & ~iss[g] & ~blk;
    end

    always_comb begin
        any = |go_vec;
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (go_vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/dmaq_top.sv
module dmaq_top
    import dmaq_pkg::*;
#(
    parameter  int DEPTH     = 16,
    parameter  int MAX_BYTES = 16384,
    localparam int IDX_W     = $clog2(DEPTH),
    localparam int CNT_W     = $clog2(DEPTH + 1),
    localparam int ID_W      = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             eng_valid,
    input  logic             eng_ready,
    output logic [ID_W-1:0]  eng_id,
    output logic [TAG_W-1:0] eng_tag,
    output logic             eng_dir,
    output logic [15:0]      eng_cls,
    output logic [SZ_W-1:0]  eng_size,
    output logic [31:0]      eng_lsa,
    output logic [63:0]      eng_ea,
    input  logic             eng_done,
    input  logic [ID_W-1:0]  eng_done_id,
    output logic             cpl_valid,
    output logic [TAG_W-1:0] cpl_tag
);

    typedef struct packed {
        logic [ID_W-1:0]  id;
        logic [TAG_W-1:0] tag;
        ord_e             ord;
        logic             dir;
        logic [15:0]      cls;
        logic [SZ_W-1:0]  size;
        logic [31:0]      lsa;
        logic [63:0]      ea;
    } ent_t;

    typedef struct packed {
        logic [31:0]            lsa_r;
        logic [31:0]            eah_r;
        logic [31:0]            eal_r;
        logic [31:0]            szt_r;
        logic [31:0]            ccm_r;
        ent_t [DEPTH-1:0]       ent;
        logic [DEPTH-1:0]       vld;
        logic [DEPTH-1:0]       iss;
        logic [CNT_W-1:0]       cnt;
        logic [ID_W-1:0]        nid;
        logic [31:0]            rdata;
        logic                   cpl_v;
        logic [TAG_W-1:0]       cpl_tag;
    } st_t;

    st_t st_d, st_q;

    // descriptor screening
    logic cmd_ok;
    dmaq_check #(
        .MAX_BYTES (MAX_BYTES),
        .SIZE_W    (SZ_W)
    ) u_check (
        .size   (st_q.szt_r[31:16]),
        .lsa_lo (st_q.lsa_r[3:0]),
        .ea_lo  (st_q.eal_r[3:0]),
        .ok     (cmd_ok)
    );

    // issue selection
    logic [DEPTH*TAG_W-1:0] tags_flat;
    logic [2*DEPTH-1:0]     ords_flat;
    logic                   pick_v;
    logic [IDX_W-1:0]       pick_idx;

    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign tags_flat[g*TAG_W +: TAG_W] = st_q.ent[g].tag;
        assign ords_flat[2*g +: 2]         = st_q.ent[g].ord;
    end

    dmaq_pick #(
        .DEPTH (DEPTH)
    ) u_pick (
        .vld  (st_q.vld),
        .iss  (st_q.iss),
        .tags (tags_flat),
        .ords (ords_flat),
        .any  (pick_v),
        .idx  (pick_idx)
    );

    // enqueue decision
    logic       stat_rd;
    logic       q_full;
    logic [1:0] stat_code;
    logic       enq_go;
    ent_t       new_ent;

    always_comb begin
        stat_rd   = reg_rd && (reg_addr == RA_STAT);
        q_full    = (st_q.cnt == CNT_W'(DEPTH));
        stat_code = !cmd_ok ? ST_BAD : (q_full ? ST_FULL : ST_OK);
        enq_go    = stat_rd && cmd_ok && !q_full;

        new_ent.id   = st_q.nid;
        new_ent.tag  = st_q.szt_r[TAG_W-1:0];
        new_ent.ord  = ord_e'(st_q.ccm_r[1:0]);
        new_ent.dir  = st_q.ccm_r[2];
        new_ent.cls  = st_q.ccm_r[31:16];
        new_ent.size = st_q.szt_r[31:16];
        new_ent.lsa  = st_q.lsa_r;
        new_ent.ea   = {st_q.eah_r, st_q.eal_r};
    end

    // next state
    logic             hit;
    logic [IDX_W-1:0] rm;
    logic [IDX_W-1:0] slot;

    always_comb begin
        st_d       = st_q;
        st_d.cpl_v = 1'b0;
        hit        = 1'b0;
        rm         = '0;
        slot       = '0;

        if (reg_wr) begin
            case (reg_addr)
                RA_LSA:    st_d.lsa_r = reg_wdata;
                RA_EAH:    st_d.eah_r = reg_wdata;
                RA_EAL:    st_d.eal_r = reg_wdata;
                RA_SZTAG:  st_d.szt_r = reg_wdata;
                RA_CLSCMD: st_d.ccm_r = reg_wdata;
                default: ;
            endcase
        end

        if (reg_rd) begin
            case (reg_addr)
                RA_LSA:    st_d.rdata = st_q.lsa_r;
                RA_EAH:    st_d.rdata = st_q.eah_r;
                RA_EAL:    st_d.rdata = st_q.eal_r;
                RA_SZTAG:  st_d.rdata = st_q.szt_r;
                RA_CLSCMD: st_d.rdata = st_q.ccm_r;
                RA_STAT:   st_d.rdata = {30'd0, stat_code};
                default:   st_d.rdata = '0;
            endcase
        end

        // handshake with the engine marks the entry as in flight
        if (pick_v && eng_ready) begin
            st_d.iss[pick_idx] = 1'b1;
        end

        // retire a finished entry and close the gap behind it
        if (eng_done) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!hit && st_q.vld[i] && st_q.iss[i] && (st_q.ent[i].id == eng_done_id)) begin
                    hit = 1'b1;
                    rm  = IDX_W'(i);
                end
            end
        end

        if (hit) begin
            st_d.cpl_v   = 1'b1;
            st_d.cpl_tag = st_q.ent[rm].tag;
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (IDX_W'(i) >= rm) begin
                    st_d.ent[i] = st_d.ent[i+1];
                    st_d.vld[i] = st_d.vld[i+1];
                    st_d.iss[i] = st_d.iss[i+1];
                end
            end
            st_d.ent[DEPTH-1] = '0;
            st_d.vld[DEPTH-1] = 1'b0;
            st_d.iss[DEPTH-1] = 1'b0;
            st_d.cnt          = st_d.cnt - CNT_W'(1);
        end

        // append behind the youngest live entry
        if (enq_go) begin
            slot            = st_d.cnt[IDX_W-1:0];
            st_d.ent[slot]  = new_ent;
            st_d.vld[slot]  = 1'b1;
            st_d.iss[slot]  = 1'b0;
            st_d.cnt        = st_d.cnt + CNT_W'(1);
            st_d.nid        = st_q.nid + ID_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // outputs
    ent_t sel;
    logic [CNT_W-1:0] occ_cnt;

    assign sel       = st_q.ent[pick_idx];
    assign occ_cnt   = st_q.cnt;
    assign eng_valid = pick_v;
    assign eng_id    = sel.id;
    assign eng_tag   = sel.tag;
    assign eng_dir   = sel.dir;
    assign eng_cls   = sel.cls;
    assign eng_size  = sel.size;
    assign eng_lsa   = sel.lsa;
    assign eng_ea    = sel.ea;
    assign reg_rdata = st_q.rdata;
    assign cpl_valid = st_q.cpl_v;
    assign cpl_tag   = st_q.cpl_tag;

endmodule

// File: rtl/dmaq_chk.sv
module dmaq_chk
    import dmaq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_rd,
    input logic [2:0]       reg_addr,
    input logic [31:0]      reg_rdata,
    input logic             cmd_ok,
    input logic [CNT_W-1:0] occ,
    input logic             eng_valid,
    input logic             eng_done,
    input logic             cpl_valid
);
    logic srd;
    assign srd = reg_rd && (reg_addr == RA_STAT);

    p_ok_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (srd && cmd_ok && occ != CNT_W'(DEPTH)) |=> (reg_rdata[1:0] == ST_OK));

    p_enq_grow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (srd && cmd_ok && occ != CNT_W'(DEPTH) && !eng_done) |=> (occ == CNT_W'($past(occ) + 1'b1)));

    p_bad_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (srd && !cmd_ok) |=> (reg_rdata[1:0] == ST_BAD));

    p_bad_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (srd && !cmd_ok && !eng_done) |=> (occ == $past(occ)));

    p_full_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (srd && cmd_ok && occ == CNT_W'(DEPTH)) |=> (reg_rdata[1:0] == ST_FULL));

    p_full_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (srd && occ == CNT_W'(DEPTH)) |=> (occ <= CNT_W'(DEPTH)));

    p_issue_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_valid |-> (occ != '0));

    p_cpl_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> $past(eng_done));

endmodule

bind dmaq_top dmaq_chk #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .cmd_ok    (cmd_ok),
    .occ       (occ_cnt),
    .eng_valid (eng_valid),
    .eng_done  (eng_done),
    .cpl_valid (cpl_valid)
);

// File: tb/dmaq_top_tb.sv
module dmaq_top_tb;
    import dmaq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        eng_valid, eng_ready = 1'b0;
    logic [4:0]  eng_id, eng_tag;
    logic        eng_dir;
    logic [15:0] eng_cls, eng_size;
    logic [31:0] eng_lsa;
    logic [63:0] eng_ea;
    logic        eng_done = 1'b0;
    logic [4:0]  eng_done_id = '0;
    logic        cpl_valid;
    logic [4:0]  cpl_tag;

    always #5 clk = ~clk;

    dmaq_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_valid(eng_valid), .eng_ready(eng_ready), .eng_id(eng_id),
        .eng_tag(eng_tag), .eng_dir(eng_dir), .eng_cls(eng_cls),
        .eng_size(eng_size), .eng_lsa(eng_lsa), .eng_ea(eng_ea),
        .eng_done(eng_done), .eng_done_id(eng_done_id),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // engine model state
    bit         eng_en = 1'b0;
    int         eng_delay = 0;
    bit         pv [16];
    logic [4:0] pid [16];
    logic [4:0] ptag [16];
    int         pcnt [16];
    int         psz [16];
    int         issue_cyc [0:1100];
    int         done_cyc [0:1100];
    int         ord_log [0:63];
    int         ord_n = 0;
    int         issue_total = 0;
    logic [31:0] tag_seen = '0;
    bit         exp_v = 1'b0;
    logic [4:0] exp_tag = '0;

    // vector: kind(2) size(16) lsa(8) ea(8) code(2); kind 0=R1 1=R2 2=R3
    localparam int NV = 14;
    localparam logic [35:0] VECS [NV] = '{
        {2'd0, 16'd1,     8'h03, 8'h07, 2'd0},
        {2'd0, 16'd2,     8'h02, 8'h06, 2'd0},
        {2'd2, 16'd2,     8'h01, 8'h00, 2'd2},
        {2'd0, 16'd4,     8'h04, 8'h0C, 2'd0},
        {2'd2, 16'd4,     8'h00, 8'h02, 2'd2},
        {2'd0, 16'd8,     8'h08, 8'h08, 2'd0},
        {2'd1, 16'd3,     8'h00, 8'h00, 2'd2},
        {2'd0, 16'd16,    8'h10, 8'h20, 2'd0},
        {2'd2, 16'd16,    8'h18, 8'h20, 2'd2},
        {2'd0, 16'd16384, 8'h00, 8'h00, 2'd0},
        {2'd1, 16'd16400, 8'h00, 8'h00, 2'd2},
        {2'd1, 16'd24,    8'h00, 8'h00, 2'd2},
        {2'd1, 16'd0,     8'h00, 8'h00, 2'd2},
        {2'd1, 16'd12,    8'h00, 8'h00, 2'd2}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // engine model, all activity away from the rising edge
    always @(negedge clk) begin : engine
        int k;
        int f;
        cyc++;
        if (exp_v) begin
            // R11: completion one cycle after done, carrying the tag
            chk({cpl_valid, cpl_tag} == {1'b1, exp_tag}, "R11", "completion",
                64'({cpl_valid, cpl_tag}), 64'({1'b1, exp_tag}));
        end
        exp_v       = 1'b0;
        eng_done    = 1'b0;
        eng_done_id = '0;
        k = -1;
        for (int i = 0; i < 16; i++) if (pv[i] && pcnt[i] == 0 && k < 0) k = i;
        if (k >= 0) begin
            eng_done    = 1'b1;
            eng_done_id = pid[k];
            pv[k]       = 1'b0;
            done_cyc[psz[k] >> 4] = cyc;
            exp_v   = 1'b1;
            exp_tag = ptag[k];
        end
        for (int i = 0; i < 16; i++) if (pv[i] && pcnt[i] > 0) pcnt[i]--;
        eng_ready = eng_en;
        if (rst_n && eng_valid && eng_ready) begin
            f = -1;
            for (int i = 0; i < 16; i++) if (!pv[i] && f < 0) f = i;
            if (f >= 0) begin
                pv[f] = 1'b1; pid[f] = eng_id; ptag[f] = eng_tag;
                pcnt[f] = eng_delay; psz[f] = int'(eng_size);
            end
            issue_cyc[int'(eng_size) >> 4] = cyc;
            if (ord_n < 64) begin
                ord_log[ord_n] = int'(eng_size);
                ord_n++;
            end
            issue_total++;
            tag_seen[eng_tag] = 1'b1;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic enq(input logic [31:0] lsa, input logic [63:0] ea, input int sz,
                       input int tag, input logic [1:0] ord, input logic dir,
                       input logic [15:0] cls, output logic [1:0] code);
        logic [15:0] s16;
        logic [4:0]  t5;
        s16 = 16'(sz);
        t5  = 5'(tag);
        wr(RA_LSA, lsa);
        wr(RA_EAH, ea[63:32]);
        wr(RA_EAL, ea[31:0]);
        wr(RA_SZTAG, {s16, 11'd0, t5});
        wr(RA_CLSCMD, {cls, 13'd0, dir, ord});
        reg_rd = 1'b1; reg_addr = RA_STAT;
        @(negedge clk);
        reg_rd = 1'b0;
        code = reg_rdata[1:0];
    endtask

    task automatic clear_logs();
        for (int i = 0; i <= 1100; i++) begin
            issue_cyc[i] = -1;
            done_cyc[i]  = -1;
        end
        ord_n = 0;
        issue_total = 0;
        tag_seen = '0;
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        summary();
        $finish;
    end

    initial begin : main
        logic [1:0] code;
        int exp_ok;
        int bad;
        string req;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        chk(eng_valid == 1'b0, "R12", "eng_valid", 64'(eng_valid), 0);
        chk(cpl_valid == 1'b0, "R12", "cpl_valid", 64'(cpl_valid), 0);
        chk(reg_rdata == 32'd0, "R12", "reg_rdata", 64'(reg_rdata), 0);

        // table walk: R1 / R2 / R3
        clear_logs();
        eng_en = 1'b1;
        eng_delay = 2;
        exp_ok = 0;
        for (int v = 0; v < NV; v++) begin
            enq(32'h0000_2000 | 32'(VECS[v][17:10]),
                64'h0000_0001_0000_0000 | 64'(VECS[v][9:2]),
                int'(VECS[v][33:18]), v, 2'd0, 1'b0, 16'h0, code);
            case (VECS[v][35:34])
                2'd0:    req = "R1";
                2'd1:    req = "R2";
                default: req = "R3";
            endcase
            chk(code == VECS[v][1:0], req, $sformatf("status of vector %0d", v),
                64'(code), 64'(VECS[v][1:0]));
            if (VECS[v][1:0] == 2'd0) exp_ok++;
        end
        repeat (30) @(negedge clk);
        chk(issue_total == exp_ok, "R1", "accepted commands issued (R2 rejects absent)",
            64'(issue_total), 64'(exp_ok));

        // R6: field layout at the engine port
        clear_logs();
        eng_en = 1'b0;
        enq(32'h0000_0040, 64'h0123_4567_89AB_CDE0, 32, 17, 2'd0, 1'b1, 16'hABCD, code);
        chk(code == 2'd0, "R6", "status", 64'(code), 0);
        chk({eng_valid, eng_tag, eng_dir, eng_cls, eng_size} == {1'b1, 5'd17, 1'b1, 16'hABCD, 16'd32},
            "R6", "valid/tag/dir/class/size",
            64'({eng_valid, eng_tag, eng_dir, eng_cls, eng_size}),
            64'({1'b1, 5'd17, 1'b1, 16'hABCD, 16'd32}));
        chk(eng_lsa == 32'h40, "R6", "local address", 64'(eng_lsa), 64'h40);
        chk(eng_ea == 64'h0123_4567_89AB_CDE0, "R6", "effective address", eng_ea, 64'h0123_4567_89AB_CDE0);
        eng_en = 1'b1;
        repeat (10) @(negedge clk);

        // R7: plain commands issue in queue order
        clear_logs();
        eng_en = 1'b0;
        eng_delay = 0;
        enq(32'h100, 64'h200, 16, 1, 2'd0, 1'b0, 16'h0, code);
        enq(32'h100, 64'h200, 32, 2, 2'd0, 1'b0, 16'h0, code);
        enq(32'h100, 64'h200, 48, 3, 2'd0, 1'b0, 16'h0, code);
        eng_en = 1'b1;
        repeat (20) @(negedge clk);
        chk(ord_n == 3 && ord_log[0] == 16 && ord_log[1] == 32 && ord_log[2] == 48,
            "R7", "issue order sizes", 64'({16'(ord_log[0]), 16'(ord_log[1]), 16'(ord_log[2])}),
            64'({16'd16, 16'd32, 16'd48}));

        // R8 and R10: fence waits, other group passes
        clear_logs();
        eng_en = 1'b0;
        eng_delay = 8;
        enq(32'h100, 64'h200, 16, 3, 2'd0, 1'b0, 16'h0, code);
        enq(32'h100, 64'h200, 32, 3, 2'd1, 1'b0, 16'h0, code);
        enq(32'h100, 64'h200, 48, 4, 2'd0, 1'b0, 16'h0, code);
        eng_en = 1'b1;
        repeat (60) @(negedge clk);
        chk(issue_cyc[3] >= 0 && issue_cyc[3] < issue_cyc[2], "R10", "other group before fence",
            64'(issue_cyc[3]), 64'(issue_cyc[2]));
        chk(issue_cyc[2] > done_cyc[1] && done_cyc[1] >= 0, "R8", "fence after older done",
            64'(issue_cyc[2]), 64'(done_cyc[1]));

        // R9 and R10: barrier
        clear_logs();
        eng_en = 1'b0;
        enq(32'h100, 64'h200, 64,  5, 2'd0, 1'b0, 16'h0, code);
        enq(32'h100, 64'h200, 80,  5, 2'd2, 1'b0, 16'h0, code);
        enq(32'h100, 64'h200, 96,  5, 2'd0, 1'b0, 16'h0, code);
        enq(32'h100, 64'h200, 112, 6, 2'd0, 1'b0, 16'h0, code);
        eng_en = 1'b1;
        repeat (80) @(negedge clk);
        chk(issue_cyc[7] >= 0 && issue_cyc[7] < issue_cyc[5], "R10", "other group before barrier",
            64'(issue_cyc[7]), 64'(issue_cyc[5]));
        chk(issue_cyc[5] > done_cyc[4] && done_cyc[4] >= 0, "R9", "barrier after older done",
            64'(issue_cyc[5]), 64'(done_cyc[4]));
        chk(issue_cyc[6] > done_cyc[5] && done_cyc[5] >= 0, "R9", "younger after barrier done",
            64'(issue_cyc[6]), 64'(done_cyc[5]));

        // R4 and R5: full queue
        clear_logs();
        eng_en = 1'b0;
        eng_delay = 1;
        bad = 0;
        for (int i = 0; i < 16; i++) begin
            enq(32'h300, 64'h400, 16, i, 2'd0, 1'b0, 16'h0, code);
            if (code != 2'd0) bad++;
        end
        chk(bad == 0, "R4", "sixteen accepted", 64'(bad), 0);
        enq(32'h300, 64'h400, 16, 20, 2'd0, 1'b0, 16'h0, code);
        chk(code == 2'd1, "R4", "full status", 64'(code), 1);
        enq(32'h300, 64'h400, 3, 21, 2'd0, 1'b0, 16'h0, code);
        chk(code == 2'd2, "R5", "malformed while full", 64'(code), 2);
        eng_en = 1'b1;
        repeat (100) @(negedge clk);
        chk(issue_total == 16 && tag_seen == 32'h0000_FFFF, "R4", "queue unchanged by rejects",
            64'({32'(issue_total), tag_seen}), 64'({32'd16, 32'h0000_FFFF}));

        summary();
        $finish;
    end
endmodule